// File: doc/BRIEF.md
# Shutter speed setting interface

This block takes the electronic-shutter speed setting of a CCD timing controller and turns it into one 8-bit shutter code for the exposure logic downstream. Three shared input pins carry the setting. A select pin decides how they are read. In serial mode they act as a data line, a shift clock and a load strobe. In parallel mode they are three static levels. Together with the video standard input (EIA or CCIR), those levels pick one of eight speeds.

Serial words arrive MSB first and collect in a shift register. They reach the active code only when the strobe rises. Parallel selections are translated into the same code space as serial words, so downstream logic sees only one format. Code 0xFF is step 0, the slowest speed, which equals the field period. When the shutter enable is low, a shutter-off flag is raised and the code output is forced to 0xFF.

All pins are asynchronous. Each is brought into the clock domain through a synchronizer before any edge detection or decoding.

Top module: `shutter_set_if`

## Requirements
- R1: While reset is asserted, and after its release until a new setting is applied, the code output is 0xFF. During reset the off flag is high.
- R2: Select low chooses serial mode. Select high chooses parallel mode.
- R3: In serial mode each rising edge of the shift-clock pin shifts the data pin into an 8-bit register, MSB first. Neither shifting nor a data change without a strobe alters the code output.
- R4: In serial mode a rising edge of the strobe pin copies the shift register into the active code.
- R5: In EIA parallel mode the pins (up, mid, down) map to codes as follows: HHH=0xF6, LHH=0xE5, HLH=0xD2, LLH=0xC2, HHL=0xB8, LHL=0xA8, HLL=0x9B, LLL=0x6A.
- R6: In CCIR parallel mode the same pin patterns map to 0xF1, 0xE3, 0xD0, 0xC0, 0xB7, 0xA6, 0x98 and 0x68, in the same order as R5.
- R7: Enable low raises the off flag and forces the code output to 0xFF. Raising enable again restores the stored active code.
- R8: Switching from parallel to serial keeps the last parallel code until a strobe arrives.
- R9: A parallel pin change reaches the code output on the third rising clock edge after it: two synchronizer stages plus the code register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| par_sel_i | input | 1 | Mode select: 0 serial, 1 parallel |
| shut_en_i | input | 1 | Shutter enable; 0 turns the shutter off |
| std_ccir_i | input | 1 | Video standard: 0 EIA, 1 CCIR |
| spd_up_i | input | 1 | Serial load strobe / parallel up level |
| spd_mid_i | input | 1 | Serial shift clock / parallel mid level |
| spd_dn_i | input | 1 | Serial data / parallel down level |
| shut_code_o | output | 8 | Active shutter code, 0xFF = slowest |
| shut_off_o | output | 1 | High while the shutter is disabled |

## Verification
The bench builds the block with its defaults: two synchronizer stages and an 8-bit code. With two stages, the three-edge latency of R9 can be pinned to an exact cycle. The 8-bit code lets every one of the sixteen parallel standard/level combinations be compared against literal codes. Serial words are checked both before and after their strobe, and the mode change holds the parallel code, so staging and pin sharing are both covered.

// File: rtl/shutter_set_pkg.sv
package shutter_set_pkg;

  localparam int CODE_W = 8;
  localparam int SEL_W  = 3;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_SLOWEST = '1;

  // idx = {~down, ~mid, ~up}: 0 is the slowest parallel speed, 7 the fastest
  function automatic code_t par_code(input logic ccir, input logic [SEL_W-1:0] idx);
    code_t c;
    case ({ccir, idx})
      4'b0_000: c = 8'hF6;
      4'b0_001: c = 8'hE5;
      4'b0_010: c = 8'hD2;
      4'b0_011: c = 8'hC2;
      4'b0_100: c = 8'hB8;
      4'b0_101: c = 8'hA8;
      4'b0_110: c = 8'h9B;
      4'b0_111: c = 8'h6A;
      4'b1_000: c = 8'hF1;
      4'b1_001: c = 8'hE3;
      4'b1_010: c = 8'hD0;
      4'b1_011: c = 8'hC0;
      4'b1_100: c = 8'hB7;
      4'b1_101: c = 8'hA6;
      4'b1_110: c = 8'h98;
      default:  c = 8'h68;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/shutter_sync.sv
module shutter_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q, stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/shutter_edge.sv
module shutter_edge #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/shutter_shift.sv
module shutter_shift #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] word_o
);

  logic [WIDTH-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en_i) word_d = {word_q[WIDTH-2:0], bit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '1;
    else         word_q <= word_d;
  end

  assign word_o = word_q;

endmodule

// File: rtl/shutter_set_if.sv
module shutter_set_if
  import shutter_set_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              par_sel_i,
  input  logic              shut_en_i,
  input  logic              std_ccir_i,
  input  logic              spd_up_i,
  input  logic              spd_mid_i,
  input  logic              spd_dn_i,
  output logic [CODE_W-1:0] shut_code_o,
  output logic              shut_off_o
);

  localparam int IDX_DN  = 0;
  localparam int IDX_MID = 1;
  localparam int IDX_UP  = 2;
  localparam int IDX_SEL = 3;
  localparam int IDX_STD = 4;
  localparam int IDX_EN  = 5;
  localparam int N_SYNC  = 6;
  localparam int N_EDGE  = 2;

  logic [N_SYNC-1:0] raw, syn;
  logic [N_EDGE-1:0] rise;
  logic              ser_mode, clk_rise, stb_rise, data_s;
  code_t             shift_q, act_q, act_d, dec_code;

  assign raw = {shut_en_i, std_ccir_i, par_sel_i, spd_up_i, spd_mid_i, spd_dn_i};

  shutter_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  shutter_edge #(.WIDTH(N_EDGE)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i ({syn[IDX_UP], syn[IDX_MID]}),
    .rise_o(rise)
  );

  assign clk_rise = rise[0];
  assign stb_rise = rise[1];
  assign ser_mode = ~syn[IDX_SEL];
  assign data_s   = syn[IDX_DN];

  shutter_shift #(.WIDTH(CODE_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(ser_mode & clk_rise),
    .bit_i     (data_s),
    .word_o    (shift_q)
  );

  assign dec_code = par_code(syn[IDX_STD], {~syn[IDX_DN], ~syn[IDX_MID], ~syn[IDX_UP]});

  always_comb begin
    act_d = act_q;
    if (ser_mode) begin
      if (stb_rise) act_d = shift_q;
    end else begin
      act_d = dec_code;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= CODE_SLOWEST;
    else         act_q <= act_d;
  end

  assign shut_off_o  = ~syn[IDX_EN];
  assign shut_code_o = syn[IDX_EN] ? act_q : CODE_SLOWEST;

endmodule

// File: rtl/shutter_set_chk.sv
module shutter_set_chk
  import shutter_set_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ser_mode,
  input logic        clk_rise,
  input logic        stb_rise,
  input logic        data_s,
  input code_t       shift_q,
  input code_t       act_q,
  input code_t       shut_code_o,
  input logic        shut_off_o
);

  a_r7_off_forces_slowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shut_off_o |-> shut_code_o == CODE_SLOWEST);

  a_r3_shift_takes_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_mode && clk_rise) |=> shift_q[0] == $past(data_s));

  a_r3_shift_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ser_mode && clk_rise) |=> $stable(shift_q));

  a_r4_strobe_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_mode && stb_rise) |=> act_q == $past(shift_q));

  a_r8_serial_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_mode && !stb_rise) |=> $stable(act_q));

endmodule

bind shutter_set_if shutter_set_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ser_mode   (ser_mode),
  .clk_rise   (clk_rise),
  .stb_rise   (stb_rise),
  .data_s     (data_s),
  .shift_q    (shift_q),
  .act_q      (act_q),
  .shut_code_o(shut_code_o),
  .shut_off_o (shut_off_o)
);

// File: tb/shutter_set_if_tb.sv
module shutter_set_if_tb;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       par_sel, shut_en, std_ccir, spd_up, spd_mid, spd_dn;
  logic [7:0] code;
  logic       off;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  shutter_set_if u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .par_sel_i  (par_sel),
    .shut_en_i  (shut_en),
    .std_ccir_i (std_ccir),
    .spd_up_i   (spd_up),
    .spd_mid_i  (spd_mid),
    .spd_dn_i   (spd_dn),
    .shut_code_o(code),
    .shut_off_o (off)
  );

  // {std, up, mid, down, code}
  localparam logic [11:0] VEC [16] = '{
    {4'b0_111, 8'hF6}, {4'b0_011, 8'hE5}, {4'b0_101, 8'hD2}, {4'b0_001, 8'hC2},
    {4'b0_110, 8'hB8}, {4'b0_010, 8'hA8}, {4'b0_100, 8'h9B}, {4'b0_000, 8'h6A},
    {4'b1_111, 8'hF1}, {4'b1_011, 8'hE3}, {4'b1_101, 8'hD0}, {4'b1_001, 8'hC0},
    {4'b1_110, 8'hB7}, {4'b1_010, 8'hA6}, {4'b1_100, 8'h98}, {4'b1_000, 8'h68}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_word(input logic [7:0] w);
    for (int i = 7; i >= 0; i--) begin
      spd_dn = w[i];
      wait_n(3);
      spd_mid = 1'b1;
      wait_n(3);
      spd_mid = 1'b0;
    end
    wait_n(3);
  endtask

  task automatic pulse_strobe();
    spd_up = 1'b1;
    wait_n(3);
    spd_up = 1'b0;
    wait_n(4);
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    par_sel = 1'b0; shut_en = 1'b1; std_ccir = 1'b0;
    spd_up = 1'b0; spd_mid = 1'b0; spd_dn = 1'b0;
    wait_n(3);
    chk("R1 code in reset", code, 8'hFF);
    chk("R1 off flag in reset", {7'd0, off}, 8'h01);
    rst_ni = 1'b1;
    wait_n(5);
    chk("R1 code after reset", code, 8'hFF);
    chk("R1 off flag after reset", {7'd0, off}, 8'h00);

    // serial path (R2: select low)
    send_word(8'hC2);
    chk("R3 no change before strobe", code, 8'hFF);
    pulse_strobe();
    chk("R4 R2 strobe loads word", code, 8'hC2);
    send_word(8'h6A);
    chk("R3 new word held back", code, 8'hC2);
    pulse_strobe();
    chk("R4 second word", code, 8'h6A);

    // enable
    shut_en = 1'b0;
    wait_n(4);
    chk("R7 off flag", {7'd0, off}, 8'h01);
    chk("R7 code forced slowest", code, 8'hFF);
    shut_en = 1'b1;
    wait_n(4);
    chk("R7 code restored", code, 8'h6A);

    // parallel table (R2: select high)
    par_sel = 1'b1;
    for (int i = 0; i < 16; i++) begin
      std_ccir = VEC[i][11];
      spd_up   = VEC[i][10];
      spd_mid  = VEC[i][9];
      spd_dn   = VEC[i][8];
      wait_n(5);
      chk(VEC[i][11] ? "R6 CCIR parallel decode" : "R5 EIA parallel decode", code, VEC[i][7:0]);
    end

    // latency R9
    std_ccir = 1'b0; spd_up = 1'b1; spd_mid = 1'b1; spd_dn = 1'b1;
    wait_n(5);
    chk("R9 setup HHH", code, 8'hF6);
    spd_up = 1'b0; spd_mid = 1'b0; spd_dn = 1'b0;
    wait_n(2);
    chk("R9 not yet after two edges", code, 8'hF6);
    wait_n(1);
    chk("R9 visible after three edges", code, 8'h6A);

    // mode change R8
    spd_up = 1'b1; spd_mid = 1'b1; spd_dn = 1'b1;
    wait_n(5);
    par_sel = 1'b0;
    wait_n(5);
    chk("R8 parallel code kept in serial", code, 8'hF6);
    spd_dn = 1'b0;
    wait_n(5);
    chk("R8 data level ignored", code, 8'hF6);
    spd_mid = 1'b0;
    wait_n(3);
    spd_mid = 1'b1;
    wait_n(5);
    chk("R3 shift clock alone ignored", code, 8'hF6);

    summary();
    $finish;
  end

endmodule